// File: doc/BRIEF.md
# Per-core local interrupt router

This block collects the interrupt sources that belong to a small cluster of processor cores and steers each of them onto one IRQ line and one FIQ line per core. Each core owns its timer sources and its mailbox summary lines, which it enables through two per-core configuration registers. The performance-monitor lines are routed through one shared routing word that is changed only through a set alias and a clear alias, so one core can change its own bits without a read-modify-write race. The single GPU line is sent to exactly one core. The AXI and local-timer lines are tied to core 0.

Software sees a 32-bit register bus with one-cycle registered read data. Each core has a read-only pending word. It shows, as a live level, every source that is currently asserted and enabled towards that core. An interrupt handler reads its own pending word to find out what to service. Mailbox storage is kept outside this block, which only receives the mailbox summary levels.

Top module: `lir_router`

## Requirements
- R1: After reset, every readable register reads 0 (control 0x00, prescaler 0x08, GPU routing 0x0C, PMU routing 0x10/0x14, timer config 0x40+4·c, mailbox config 0x50+4·c). With all sources low, every irq_o and fiq_o bit is 0.
- R2: Control (0x00) and prescaler (0x08) are full 32-bit read/write words. A prescaler value of 0x80000000 (the 19.2 MHz timebase setting) reads back unchanged.
- R3: Timer config of core c at 0x40+4·c: bit n enables that core's timer source n (timer_src_i[c*4+n]) onto its IRQ, and bit n+4 enables it onto its FIQ. Bits above 7 read as 0. Writing 0 disables all four timer sources of that core.
- R4: Mailbox config of core c at 0x50+4·c uses the same layout for that core's mailbox summary lines mbox_src_i[c*4+n].
- R5: A write to 0x10 ORs data bits [7:0] into the PMU routing word. A write to 0x14 clears the bits written as 1. Both addresses read back the routing word. Bit c routes pmu_src_i[c] to the IRQ of core c, and bit c+4 routes it to the FIQ of core c.
- R6: GPU routing at 0x0C: bits [1:0] name the IRQ core, bits [3:2] name the FIQ core, and bit 4 set selects the FIQ path. Only these 5 bits are stored. gpu_irq_i appears in pending bit 8 of the selected core only, and drives that core's IRQ when bit 4 is 0, or its FIQ when bit 4 is 1.
- R7: Pending word of core c at 0x60+4·c: bits 3:0 are timers, bits 7:4 are mailboxes, bit 8 is GPU, bit 9 is PMU, bit 10 is AXI, bit 11 is the local timer. A bit is set while its source is high and enabled to that core's IRQ or FIQ. Writes to the pending word are ignored, and reading it changes nothing.
- R8: irq_o[c] is the OR of the pending sources of core c that are not FIQ-enabled. fiq_o[c] is the OR of the FIQ-enabled ones. A source enabled for both goes to FIQ only.
- R9: axi_irq_i and ltimer_irq_i show in pending bits 10 and 11 of core 0 only, and drive the IRQ of core 0.
- R10: Reads of undefined or misaligned offsets return 0. Writes to them change no register.
- R11: rd_data_o takes the addressed value at the clock edge that accepts a read, and holds it until the next read, across any writes in between. Outputs follow a register write from the edge that accepts it, and follow source inputs within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Bus access this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 8 | Byte offset |
| req_wdata_i | input | 32 | Write data |
| rd_data_o | output | 32 | Registered read data |
| timer_src_i | input | 16 | Timer sources, core c source n at bit c*4+n |
| mbox_src_i | input | 16 | Mailbox summaries, core c mailbox n at bit c*4+n |
| gpu_irq_i | input | 1 | Shared GPU interrupt |
| pmu_src_i | input | 4 | Per-core performance-monitor interrupt |
| axi_irq_i | input | 1 | AXI-outstanding source (tied off in use) |
| ltimer_irq_i | input | 1 | Local timer source (tied off in use) |
| irq_o | output | 4 | IRQ per core |
| fiq_o | output | 4 | FIQ per core |

## Verification
A bus write to an enable register and a change on the source it gates can fall in the same cycle. The bench drives a timer config write and the timer level together on one falling edge. Before the rising edge, the output must still reflect the old enable with the new level. After the edge, it must reflect the new enable. Both orders are judged: the enable being removed while the source rises, and the enable being granted while it rises. A read-data hold across a later write is also judged, so the captured word must not follow the register.

// File: rtl/lir_pkg.sv
package lir_pkg;

  localparam int NCORE_DEF = 4;
  localparam int NSRC_DEF  = 4;
  localparam int ADDR_W    = 8;
  localparam int DATA_W    = 32;

  localparam logic [ADDR_W-1:0] OFS_CTRL  = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_PRESC = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_GPU   = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_PSET  = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_PCLR  = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_TCFG  = 8'h40;
  localparam logic [ADDR_W-1:0] OFS_MCFG  = 8'h50;
  localparam logic [ADDR_W-1:0] OFS_PEND  = 8'h60;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_PRESC,
    SEL_GPU,
    SEL_PSET,
    SEL_PCLR,
    SEL_TCFG,
    SEL_MCFG,
    SEL_PEND
  } reg_sel_e;

endpackage

// File: rtl/lir_decode.sv
module lir_decode
  import lir_pkg::*;
#(
  parameter int NCORE  = NCORE_DEF,
  parameter int CORE_W = 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o,
  output logic [CORE_W-1:0] core_o
);

  localparam logic [ADDR_W-1:0] TCFG_END = (ADDR_W)'(int'(OFS_TCFG) + 4*NCORE);
  localparam logic [ADDR_W-1:0] MCFG_END = (ADDR_W)'(int'(OFS_MCFG) + 4*NCORE);
  localparam logic [ADDR_W-1:0] PEND_END = (ADDR_W)'(int'(OFS_PEND) + 4*NCORE);

  always_comb begin
    sel_o  = SEL_NONE;
    core_o = addr_i[2 +: CORE_W];
    if (addr_i[1:0] == 2'b00) begin
      if (addr_i == OFS_CTRL)                               sel_o = SEL_CTRL;
      else if (addr_i == OFS_PRESC)                         sel_o = SEL_PRESC;
      else if (addr_i == OFS_GPU)                           sel_o = SEL_GPU;
      else if (addr_i == OFS_PSET)                          sel_o = SEL_PSET;
      else if (addr_i == OFS_PCLR)                          sel_o = SEL_PCLR;
      else if (addr_i >= OFS_TCFG && addr_i < TCFG_END)     sel_o = SEL_TCFG;
      else if (addr_i >= OFS_MCFG && addr_i < MCFG_END)     sel_o = SEL_MCFG;
      else if (addr_i >= OFS_PEND && addr_i < PEND_END)     sel_o = SEL_PEND;
    end
  end

endmodule

// File: rtl/lir_regs.sv
module lir_regs
  import lir_pkg::*;
#(
  parameter int NCORE  = NCORE_DEF,
  parameter int NSRC   = NSRC_DEF,
  parameter int CORE_W = 2,
  localparam int EN_W  = 2*NSRC,
  localparam int PMU_W = 2*NCORE,
  localparam int GPU_W = 2*CORE_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  reg_sel_e          sel_i,
  input  logic [CORE_W-1:0] core_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] ctrl_o,
  output logic [DATA_W-1:0] presc_o,
  output logic [GPU_W-1:0]  gpu_o,
  output logic [PMU_W-1:0]  pmu_o,
  output logic [EN_W-1:0]   tcfg_o [NCORE],
  output logic [EN_W-1:0]   mcfg_o [NCORE]
);

  logic [DATA_W-1:0] ctrl_q,  ctrl_d;
  logic [DATA_W-1:0] presc_q, presc_d;
  logic [GPU_W-1:0]  gpu_q,   gpu_d;
  logic [PMU_W-1:0]  pmu_q,   pmu_d;
  logic [EN_W-1:0]   tcfg_q [NCORE];
  logic [EN_W-1:0]   tcfg_d [NCORE];
  logic [EN_W-1:0]   mcfg_q [NCORE];
  logic [EN_W-1:0]   mcfg_d [NCORE];
  logic              state_we;

  // a write changes state only when it lands on a writable register
  always_comb begin
    state_we = 1'b0;
    if (wr_en_i) begin
      case (sel_i)
        SEL_CTRL, SEL_PRESC, SEL_GPU, SEL_PSET,
        SEL_PCLR, SEL_TCFG, SEL_MCFG: state_we = 1'b1;
        default:                      state_we = 1'b0;
      endcase
    end
  end

  always_comb begin
    ctrl_d  = ctrl_q;
    presc_d = presc_q;
    gpu_d   = gpu_q;
    pmu_d   = pmu_q;
    tcfg_d  = tcfg_q;
    mcfg_d  = mcfg_q;
    case (sel_i)
      SEL_CTRL:  ctrl_d  = wdata_i;
      SEL_PRESC: presc_d = wdata_i;
      SEL_GPU:   gpu_d   = wdata_i[GPU_W-1:0];
      SEL_PSET:  pmu_d   = pmu_q | wdata_i[PMU_W-1:0];
      SEL_PCLR:  pmu_d   = pmu_q & ~wdata_i[PMU_W-1:0];
      SEL_TCFG:  tcfg_d[core_i] = wdata_i[EN_W-1:0];
      SEL_MCFG:  mcfg_d[core_i] = wdata_i[EN_W-1:0];
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      presc_q <= '0;
      gpu_q   <= '0;
      pmu_q   <= '0;
      for (int c = 0; c < NCORE; c++) begin
        tcfg_q[c] <= '0;
        mcfg_q[c] <= '0;
      end
    end else if (state_we) begin
      ctrl_q  <= ctrl_d;
      presc_q <= presc_d;
      gpu_q   <= gpu_d;
      pmu_q   <= pmu_d;
      for (int c = 0; c < NCORE; c++) begin
        tcfg_q[c] <= tcfg_d[c];
        mcfg_q[c] <= mcfg_d[c];
      end
    end
  end

  assign ctrl_o  = ctrl_q;
  assign presc_o = presc_q;
  assign gpu_o   = gpu_q;
  assign pmu_o   = pmu_q;
  assign tcfg_o  = tcfg_q;
  assign mcfg_o  = mcfg_q;

  // R5
  pmu_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && sel_i == SEL_PSET) |=>
      ((pmu_q & $past(wdata_i[PMU_W-1:0])) == $past(wdata_i[PMU_W-1:0])));

  // R5
  pmu_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && sel_i == SEL_PCLR) |=>
      ((pmu_q & $past(wdata_i[PMU_W-1:0])) == '0));

  // R10
  undef_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (sel_i == SEL_NONE || sel_i == SEL_PEND)) |=>
      ($stable(ctrl_q) && $stable(presc_q) && $stable(gpu_q) && $stable(pmu_q)));

endmodule

// File: rtl/lir_core_view.sv
module lir_core_view
  import lir_pkg::*;
#(
  parameter int NSRC    = NSRC_DEF,
  parameter bit IS_ROOT = 1'b0,
  localparam int EN_W   = 2*NSRC,
  localparam int PEND_W = 2*NSRC + 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NSRC-1:0]   tmr_src_i,
  input  logic [NSRC-1:0]   mbx_src_i,
  input  logic [EN_W-1:0]   tcfg_i,
  input  logic [EN_W-1:0]   mcfg_i,
  input  logic              gpu_src_i,
  input  logic              gpu_irq_sel_i,
  input  logic              gpu_fiq_sel_i,
  input  logic              pmu_src_i,
  input  logic              pmu_irq_en_i,
  input  logic              pmu_fiq_en_i,
  input  logic              axi_src_i,
  input  logic              ltm_src_i,
  output logic [PEND_W-1:0] pend_o,
  output logic              irq_o,
  output logic              fiq_o
);

  localparam int PB_TMR = 0;
  localparam int PB_MBX = NSRC;
  localparam int PB_GPU = 2*NSRC;
  localparam int PB_PMU = 2*NSRC + 1;
  localparam int PB_AXI = 2*NSRC + 2;
  localparam int PB_LTM = 2*NSRC + 3;

  logic [PEND_W-1:0] src_v;
  logic [PEND_W-1:0] irq_en_v;
  logic [PEND_W-1:0] fiq_en_v;

  always_comb begin
    src_v    = '0;
    irq_en_v = '0;
    fiq_en_v = '0;
    src_v[PB_TMR +: NSRC]    = tmr_src_i;
    irq_en_v[PB_TMR +: NSRC] = tcfg_i[NSRC-1:0];
    fiq_en_v[PB_TMR +: NSRC] = tcfg_i[EN_W-1:NSRC];
    src_v[PB_MBX +: NSRC]    = mbx_src_i;
    irq_en_v[PB_MBX +: NSRC] = mcfg_i[NSRC-1:0];
    fiq_en_v[PB_MBX +: NSRC] = mcfg_i[EN_W-1:NSRC];
    src_v[PB_GPU]    = gpu_src_i;
    irq_en_v[PB_GPU] = gpu_irq_sel_i;
    fiq_en_v[PB_GPU] = gpu_fiq_sel_i;
    src_v[PB_PMU]    = pmu_src_i;
    irq_en_v[PB_PMU] = pmu_irq_en_i;
    fiq_en_v[PB_PMU] = pmu_fiq_en_i;
    src_v[PB_AXI]    = axi_src_i;
    irq_en_v[PB_AXI] = IS_ROOT;
    src_v[PB_LTM]    = ltm_src_i;
    irq_en_v[PB_LTM] = IS_ROOT;
  end

  // FIQ takes precedence: a FIQ-enabled source never reaches IRQ
  assign pend_o = src_v & (irq_en_v | fiq_en_v);
  assign fiq_o  = |(pend_o & fiq_en_v);
  assign irq_o  = |(pend_o & ~fiq_en_v);

  // R8
  line_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o || fiq_o) == (pend_o != '0));

  // R3
  tcfg_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tcfg_i == '0) |-> (pend_o[PB_TMR +: NSRC] == '0));

  // R8
  fiq_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((tcfg_i[NSRC-1:0] & tmr_src_i) != '0 && (tcfg_i[EN_W-1:NSRC] == tcfg_i[NSRC-1:0])
     && mcfg_i == '0 && !gpu_src_i && !pmu_src_i && !axi_src_i && !ltm_src_i)
      |-> (fiq_o && !irq_o));

endmodule

// File: rtl/lir_router.sv
module lir_router
  import lir_pkg::*;
#(
  parameter int NCORE = NCORE_DEF,
  parameter int NSRC  = NSRC_DEF
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_valid_i,
  input  logic                  req_write_i,
  input  logic [ADDR_W-1:0]     req_addr_i,
  input  logic [DATA_W-1:0]     req_wdata_i,
  output logic [DATA_W-1:0]     rd_data_o,
  input  logic [NCORE*NSRC-1:0] timer_src_i,
  input  logic [NCORE*NSRC-1:0] mbox_src_i,
  input  logic                  gpu_irq_i,
  input  logic [NCORE-1:0]      pmu_src_i,
  input  logic                  axi_irq_i,
  input  logic                  ltimer_irq_i,
  output logic [NCORE-1:0]      irq_o,
  output logic [NCORE-1:0]      fiq_o
);

  localparam int CORE_W = (NCORE > 1) ? $clog2(NCORE) : 1;
  localparam int EN_W   = 2*NSRC;
  localparam int PMU_W  = 2*NCORE;
  localparam int GPU_W  = 2*CORE_W + 1;
  localparam int PEND_W = 2*NSRC + 4;
  localparam int PB_GPU = 2*NSRC;

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  reg_sel_e          sel;
  logic [CORE_W-1:0] core_idx;
  logic              wr_en, rd_en;

  assign wr_en = req_valid_i &  req_write_i;
  assign rd_en = req_valid_i & ~req_write_i;

  lir_decode #(.NCORE(NCORE), .CORE_W(CORE_W)) u_decode (
    .addr_i (req_addr_i),
    .sel_o  (sel),
    .core_o (core_idx)
  );

  logic [DATA_W-1:0] ctrl_q, presc_q;
  logic [GPU_W-1:0]  gpu_q;
  logic [PMU_W-1:0]  pmu_q;
  logic [EN_W-1:0]   tcfg_q [NCORE];
  logic [EN_W-1:0]   mcfg_q [NCORE];

  lir_regs #(.NCORE(NCORE), .NSRC(NSRC), .CORE_W(CORE_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_sync_q),
    .wr_en_i (wr_en),
    .sel_i   (sel),
    .core_i  (core_idx),
    .wdata_i (req_wdata_i),
    .ctrl_o  (ctrl_q),
    .presc_o (presc_q),
    .gpu_o   (gpu_q),
    .pmu_o   (pmu_q),
    .tcfg_o  (tcfg_q),
    .mcfg_o  (mcfg_q)
  );

  logic [CORE_W-1:0] gpu_irq_core, gpu_fiq_core;
  logic              gpu_to_fiq;
  assign gpu_irq_core = gpu_q[CORE_W-1:0];
  assign gpu_fiq_core = gpu_q[2*CORE_W-1:CORE_W];
  assign gpu_to_fiq   = gpu_q[2*CORE_W];

  logic [PEND_W-1:0] pend [NCORE];
  logic [NCORE-1:0]  gpu_seen;

  for (genvar c = 0; c < NCORE; c++) begin : g_core
    logic gpu_irq_sel, gpu_fiq_sel;
    assign gpu_irq_sel = !gpu_to_fiq && (gpu_irq_core == CORE_W'(c));
    assign gpu_fiq_sel =  gpu_to_fiq && (gpu_fiq_core == CORE_W'(c));

    lir_core_view #(.NSRC(NSRC), .IS_ROOT(c == 0)) u_view (
      .clk_i         (clk_i),
      .rst_ni        (rst_sync_q),
      .tmr_src_i     (timer_src_i[c*NSRC +: NSRC]),
      .mbx_src_i     (mbox_src_i[c*NSRC +: NSRC]),
      .tcfg_i        (tcfg_q[c]),
      .mcfg_i        (mcfg_q[c]),
      .gpu_src_i     (gpu_irq_i),
      .gpu_irq_sel_i (gpu_irq_sel),
      .gpu_fiq_sel_i (gpu_fiq_sel),
      .pmu_src_i     (pmu_src_i[c]),
      .pmu_irq_en_i  (pmu_q[c]),
      .pmu_fiq_en_i  (pmu_q[NCORE + c]),
      .axi_src_i     (axi_irq_i),
      .ltm_src_i     (ltimer_irq_i),
      .pend_o        (pend[c]),
      .irq_o         (irq_o[c]),
      .fiq_o         (fiq_o[c])
    );

    assign gpu_seen[c] = pend[c][PB_GPU];
  end

  logic [DATA_W-1:0] rd_d, rd_q;

  always_comb begin
    case (sel)
      SEL_CTRL:          rd_d = ctrl_q;
      SEL_PRESC:         rd_d = presc_q;
      SEL_GPU:           rd_d = DATA_W'(gpu_q);
      SEL_PSET, SEL_PCLR: rd_d = DATA_W'(pmu_q);
      SEL_TCFG:          rd_d = DATA_W'(tcfg_q[core_idx]);
      SEL_MCFG:          rd_d = DATA_W'(mcfg_q[core_idx]);
      SEL_PEND:          rd_d = DATA_W'(pend[core_idx]);
      default:           rd_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_sync_q) begin
    if (!rst_sync_q)  rd_q <= '0;
    else if (rd_en)   rd_q <= rd_d;
  end

  assign rd_data_o = rd_q;

  // R6
  gpu_single_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_q)
    $countones(gpu_seen) <= 1);

  // R7
  read_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_q)
    rd_en |=> ($stable(pmu_q) && $stable(gpu_q) && $stable(ctrl_q) && $stable(presc_q)));

  // R10
  undef_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_q)
    (rd_en && sel == SEL_NONE) |=> (rd_data_o == '0));

  // R11
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_q)
    !rd_en |=> $stable(rd_data_o));

endmodule

// File: tb/test_lir_router.sv
module test_lir_router;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [7:0]  req_addr;
  logic [31:0] req_wdata;
  logic [31:0] rd_data;
  logic [15:0] timer_src, mbox_src;
  logic        gpu_irq, axi_irq, ltimer_irq;
  logic [3:0]  pmu_src;
  logic [3:0]  irq, fiq;

  always #4 clk = ~clk;

  lir_router i_lir_router (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .req_valid_i  (req_valid),
    .req_write_i  (req_write),
    .req_addr_i   (req_addr),
    .req_wdata_i  (req_wdata),
    .rd_data_o    (rd_data),
    .timer_src_i  (timer_src),
    .mbox_src_i   (mbox_src),
    .gpu_irq_i    (gpu_irq),
    .pmu_src_i    (pmu_src),
    .axi_irq_i    (axi_irq),
    .ltimer_irq_i (ltimer_irq),
    .irq_o        (irq),
    .fiq_o        (fiq)
  );

  typedef struct {
    int          due;
    bit          is_rd;
    logic [31:0] exp;
    string       req;
  } item_t;

  item_t sbq[$];
  int    cyc = 0;
  int    n_chk = 0;
  int    n_bad = 0;
  bit    done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compares every item that has fallen due
  always @(negedge clk) begin
    #2;
    while (sbq.size() > 0 && sbq[0].due <= cyc) begin
      item_t it;
      logic [31:0] act;
      it  = sbq.pop_front();
      act = it.is_rd ? rd_data : {24'h0, fiq, irq};
      n_chk++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s: actual=%h expected=%h", it.req, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string r);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    sbq.push_back('{due: cyc + 1, is_rd: 1'b1, exp: e, req: r});
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // expected {fiq[3:0], irq[3:0]} in the current cycle
  task automatic chk_out(input logic [7:0] e, input string r);
    sbq.push_back('{due: cyc, is_rd: 1'b0, exp: {24'h0, e}, req: r});
    @(negedge clk);
  endtask

  task automatic chk_hold(input logic [31:0] e, input string r);
    sbq.push_back('{due: cyc, is_rd: 1'b1, exp: e, req: r});
    @(negedge clk);
  endtask

  task automatic quiet();
    timer_src = '0; mbox_src = '0; gpu_irq = 0; pmu_src = '0;
    axi_irq = 0; ltimer_irq = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R11 watchdog: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0;
    quiet();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(8'h00, 32'h0, "R1 control");
    rd(8'h08, 32'h0, "R1 prescaler");
    rd(8'h0C, 32'h0, "R1 gpu routing");
    rd(8'h10, 32'h0, "R1 pmu routing");
    rd(8'h44, 32'h0, "R1 timer cfg core1");
    rd(8'h5C, 32'h0, "R1 mailbox cfg core3");
    chk_out(8'h00, "R1 lines idle");

    // R2 storage words
    wr(8'h08, 32'h8000_0000);
    rd(8'h08, 32'h8000_0000, "R2 prescaler");
    wr(8'h00, 32'hA5A5_0001);
    rd(8'h00, 32'hA5A5_0001, "R2 control");

    // R3 / R8 timer path on core 1
    timer_src[4] = 1'b1;
    chk_out(8'h00, "R3 timer disabled");
    wr(8'h44, 32'h01);
    chk_out(8'h02, "R3 timer0 to IRQ core1");
    rd(8'h64, 32'h001, "R7 pending core1 timer");
    wr(8'h44, 32'h10);
    chk_out(8'h20, "R8 timer0 to FIQ core1");
    wr(8'h44, 32'h11);
    chk_out(8'h20, "R8 both enables give FIQ only");
    wr(8'h44, 32'h0);
    chk_out(8'h00, "R3 zero write disables");
    rd(8'h64, 32'h0, "R3 pending cleared by disable");
    wr(8'h44, 32'hFFFF_FFFF);
    rd(8'h44, 32'h0000_00FF, "R3 upper bits read zero");
    wr(8'h44, 32'h0);
    quiet();

    // R4 mailbox path on core 2
    mbox_src[11] = 1'b1;
    wr(8'h58, 32'h08);
    chk_out(8'h04, "R4 mailbox3 to IRQ core2");
    rd(8'h68, 32'h080, "R4 pending core2 mailbox3");
    wr(8'h58, 32'h80);
    chk_out(8'h40, "R4 mailbox3 to FIQ core2");
    wr(8'h58, 32'h0);
    quiet();

    // R5 PMU set/clear aliases
    pmu_src = 4'hF;
    wr(8'h10, 32'h05);
    rd(8'h10, 32'h05, "R5 set alias");
    chk_out(8'h05, "R5 IRQ cores 0 and 2");
    wr(8'h10, 32'h80);
    rd(8'h10, 32'h85, "R5 set ORs in");
    chk_out(8'h85, "R5 FIQ core3 added");
    wr(8'h14, 32'h04);
    rd(8'h14, 32'h81, "R5 clear alias");
    chk_out(8'h81, "R5 core2 removed");
    rd(8'h6C, 32'h200, "R7 pending core3 pmu");
    wr(8'h14, 32'hFF);
    rd(8'h10, 32'h0, "R5 all cleared");
    quiet();

    // R6 GPU routing
    gpu_irq = 1'b1;
    chk_out(8'h01, "R6 default to core0 IRQ");
    rd(8'h60, 32'h100, "R6 pending core0 gpu");
    rd(8'h64, 32'h000, "R6 core1 not pending");
    wr(8'h0C, 32'h02);
    chk_out(8'h04, "R6 IRQ core2");
    rd(8'h68, 32'h100, "R6 pending core2 gpu");
    rd(8'h60, 32'h000, "R6 core0 no longer pending");
    wr(8'h0C, 32'h1C);
    chk_out(8'h80, "R6 FIQ core3");
    rd(8'h6C, 32'h100, "R6 pending core3 gpu");
    rd(8'h0C, 32'h1C, "R6 routing readback");
    wr(8'h0C, 32'hFFFF_FFE2);
    rd(8'h0C, 32'h02, "R6 only five bits kept");
    wr(8'h0C, 32'h0);
    quiet();

    // R9 tied-off sources
    axi_irq = 1'b1;
    chk_out(8'h01, "R9 axi to core0 IRQ");
    rd(8'h60, 32'h400, "R9 pending axi");
    ltimer_irq = 1'b1;
    rd(8'h60, 32'hC00, "R9 pending axi and local timer");
    rd(8'h64, 32'h000, "R9 core1 unaffected");
    chk_out(8'h01, "R9 only core0 IRQ");
    quiet();

    // R10 undefined offsets, R7 pending write ignored
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04, 32'h0, "R10 undefined read");
    rd(8'h00, 32'hA5A5_0001, "R10 control untouched");
    rd(8'h42, 32'h0, "R10 misaligned read");
    rd(8'h70, 32'h0, "R10 past pending range");
    wr(8'h60, 32'hFFFF_FFFF);
    rd(8'h60, 32'h0, "R7 pending write ignored");
    rd(8'h40, 32'h0, "R7 timer cfg untouched");
    chk_out(8'h00, "R7 lines quiet after pending write");

    // R11 read hold across a write
    rd(8'h08, 32'h8000_0000, "R11 read before write");
    wr(8'h08, 32'h0000_1234);
    chk_hold(32'h8000_0000, "R11 read data held");
    rd(8'h08, 32'h0000_1234, "R11 new value read");

    // R11 enable write and source change in the same cycle
    wr(8'h40, 32'h01);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h40; req_wdata = 32'h0;
    timer_src[0] = 1'b1;
    sbq.push_back('{due: cyc, is_rd: 1'b0, exp: 32'h01, req: "R11 old enable before edge"});
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    chk_out(8'h00, "R11 new enable after edge");
    timer_src[0] = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h40; req_wdata = 32'h10;
    timer_src[0] = 1'b1;
    sbq.push_back('{due: cyc, is_rd: 1'b0, exp: 32'h00, req: "R11 no enable before edge"});
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    chk_out(8'h10, "R11 FIQ enable after edge");
    quiet();

    repeat (3) @(negedge clk);
    if (sbq.size() != 0) begin
      n_bad++;
      $display("FAIL R11 scoreboard: actual=%0d left expected=0", sbq.size());
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule